// File: doc/BRIEF.md
# Timer Compare Output Waveform Generator

This block is an 8-bit timer/counter with one compare register and one compare output. A 2-bit counting-mode field selects one of four ways to count: a free-running up counter, a counter that clears when it reaches the compare value, a fast PWM sawtooth, and a phase-correct PWM triangle. A separate 2-bit output-action field sets how the output reacts to compare matches and to the counter's end points. What an output-action code does depends on the counting mode.

The counter moves only on cycles where the tick input is high, so an external prescaler sets its rate. In both PWM modes the compare value is double-buffered and is taken at TOP. In the two non-PWM modes it acts at once. The block drives the counter value, the waveform bit, a flag that says whether the waveform should own the pin, and two one-cycle event flags: compare match and overflow.

Top module: `tmr_wavegen`

## Requirements
- R1: After reset, `count_o`, `wave_o`, `match_o` and `ovf_o` are all 0, the phase-correct direction is up and the buffered compare value is 0.
- R2: All registers update only on a clock edge where `tick_i` is high. After a cycle with `tick_i` low, `count_o` is unchanged and `match_o` and `ovf_o` are 0.
- R3: With `wave_mode_i` = 00 (normal) or 11 (fast PWM), the counter counts 0 to 255 and wraps to 0. `ovf_o` is high for exactly the cycle in which `count_o` has just wrapped from 255 to 0.
- R4: With `wave_mode_i` = 10 (clear on compare), a tick taken while the count equals `cmp_val_i` loads 0; any other tick adds 1. A new `cmp_val_i` acts from the next tick, and `ovf_o` stays low.
- R5: With `wave_mode_i` = 01 (phase-correct), the counter counts up to 255 and then down to 0, and turns at each end without repeating it (…254, 255, 254…, …1, 0, 1…). `ovf_o` is high in the cycle in which the counter has just reached 0 while counting down.
- R6: `pin_en_o` is 0 when `out_mode_i` = 00 in any counting mode, and when `out_mode_i` = 01 in either PWM mode. Otherwise it is 1. While the output is disconnected, `wave_o` keeps its value.
- R7: In normal and clear-on-compare modes, a match makes `wave_o` do the following: toggle for `out_mode_i` 01, go to 0 for 10, and go to 1 for 11.
- R8: In fast PWM with `out_mode_i` 10, a match sets `wave_o` to 0 and reaching 0 sets it to 1. With `out_mode_i` 11 the levels are swapped. When a match and BOTTOM happen on the same tick, the match action wins.
- R9: In phase-correct PWM with `out_mode_i` 10, a match reached while counting up sets `wave_o` to 0, and one reached while counting down sets it to 1. With `out_mode_i` 11 the levels are swapped.
- R10: When `out_mode_i[1]` is 1 and the active compare value is 255, matches do not change `wave_o`. The BOTTOM-style action is applied instead: at count 0 in fast PWM, and at count 255 in phase-correct PWM. This drives 1 for code 10 and 0 for code 11.
- R11: In both PWM modes the active compare value is loaded from `cmp_val_i` on the tick that brings the counter to 255, and the match at 255 itself still uses the old value. In non-PWM modes `cmp_val_i` is used directly.
- R12: `match_o` is high for one cycle right after a tick whose new count equals the active compare value. `wave_o` shows the match action in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable, one step per high cycle |
| wave_mode_i | input | 2 | Counting mode: 00 normal, 01 phase-correct, 10 clear on compare, 11 fast PWM |
| out_mode_i | input | 2 | Output action code |
| cmp_val_i | input | 8 | Compare value |
| count_o | output | 8 | Counter value |
| wave_o | output | 1 | Compare output waveform |
| pin_en_o | output | 1 | Waveform owns the pin |
| match_o | output | 1 | One-cycle compare match flag |
| ovf_o | output | 1 | One-cycle overflow / BOTTOM flag |

## Verification
Each result of a tick is registered, so `count_o`, `wave_o`, `match_o` and `ovf_o` all show the effect of a tick one rising edge after the cycle in which `tick_i` was high. `pin_en_o` is combinational and follows the mode inputs in the same cycle. The bench drives inputs and then advances its arithmetic model by one step for the coming edge. It compares every output at the next falling edge, so each comparison lands in the cycle in which the result is due. The compare value is changed partway through each run so that the buffered value's hand-over at TOP is checked against the model cycle by cycle.

// File: rtl/tmr_wavegen_pkg.sv
package tmr_wavegen_pkg;
  typedef enum logic [1:0] {
    WM_NORMAL = 2'b00,
    WM_PHASE  = 2'b01,
    WM_CTC    = 2'b10,
    WM_FAST   = 2'b11
  } wave_mode_e;

  typedef enum logic [1:0] {
    OM_OFF  = 2'b00,
    OM_ALT  = 2'b01,
    OM_LOW  = 2'b10,
    OM_HIGH = 2'b11
  } out_mode_e;
endpackage

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_wavegen_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  wave_mode_e   mode_i,
  input  logic [W-1:0] ctc_top_i,
  output logic [W-1:0] cnt_q_o,
  output logic [W-1:0] cnt_d_o,
  output logic         up_d_o,
  output logic         ovf_d_o
);
  localparam logic [W-1:0] CNT_MAX = '1;
  localparam logic [W-1:0] CNT_ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         up_q, up_d, ovf_d;

  always_comb begin
    up_d  = 1'b1;
    cnt_d = cnt_q + CNT_ONE;
    ovf_d = 1'b0;
    case (mode_i)
      WM_NORMAL, WM_FAST: ovf_d = (cnt_q == CNT_MAX);
      WM_CTC: begin
        if (cnt_q == ctc_top_i) cnt_d = '0;
      end
      WM_PHASE: begin
        up_d  = up_q ? (cnt_q != CNT_MAX) : (cnt_q == '0);
        cnt_d = up_d ? (cnt_q + CNT_ONE) : (cnt_q - CNT_ONE);
        ovf_d = !up_d && (cnt_q == CNT_ONE);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (tick_i) begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt_q_o = cnt_q;
  assign cnt_d_o = cnt_d;
  assign up_d_o  = up_d;
  assign ovf_d_o = ovf_d;
endmodule

// File: rtl/tmr_cmp_buf.sv
module tmr_cmp_buf #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         pwm_i,
  input  logic [W-1:0] cnt_d_i,
  input  logic [W-1:0] cmp_val_i,
  output logic [W-1:0] cmp_eff_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] act_q;
  logic         load_en;

  // PWM: take the new value at TOP; otherwise track the input continuously
  assign load_en = !pwm_i || (tick_i && (cnt_d_i == CNT_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      act_q <= '0;
    else if (load_en) act_q <= cmp_val_i;
  end

  assign cmp_eff_o = pwm_i ? act_q : cmp_val_i;
endmodule

// File: rtl/tmr_out_ctl.sv
module tmr_out_ctl
  import tmr_wavegen_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  wave_mode_e   wmode_i,
  input  out_mode_e    omode_i,
  input  logic [W-1:0] cnt_d_i,
  input  logic         up_d_i,
  input  logic [W-1:0] cmp_eff_i,
  output logic         wave_o,
  output logic         match_o,
  output logic         pin_en_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic wave_q, wave_d, match_q, match_d;
  logic hit, at_top, at_bot, special, pwm;

  assign hit     = (cnt_d_i == cmp_eff_i);
  assign at_top  = (cnt_d_i == CNT_MAX);
  assign at_bot  = (cnt_d_i == '0);
  assign special = omode_i[1] && (cmp_eff_i == CNT_MAX);
  assign pwm     = (wmode_i == WM_PHASE) || (wmode_i == WM_FAST);

  always_comb begin
    wave_d  = wave_q;
    match_d = tick_i && hit;
    case (wmode_i)
      WM_NORMAL, WM_CTC: begin
        if (hit) begin
          case (omode_i)
            OM_ALT:  wave_d = !wave_q;
            OM_LOW:  wave_d = 1'b0;
            OM_HIGH: wave_d = 1'b1;
            default: ;
          endcase
        end
      end
      WM_FAST: begin
        if (omode_i[1]) begin
          if (special) begin
            if (at_bot) wave_d = (omode_i == OM_LOW);
          end else if (hit) begin
            wave_d = (omode_i == OM_HIGH);
          end else if (at_bot) begin
            wave_d = (omode_i == OM_LOW);
          end
        end
      end
      WM_PHASE: begin
        if (omode_i[1]) begin
          if (special) begin
            if (at_top) wave_d = (omode_i == OM_LOW);
          end else if (hit) begin
            wave_d = up_d_i ? (omode_i == OM_HIGH) : (omode_i == OM_LOW);
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wave_q <= 1'b0;
    else if (tick_i) wave_q <= wave_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b0;
    else         match_q <= match_d;
  end

  assign wave_o   = wave_q;
  assign match_o  = match_q;
  assign pin_en_o = (omode_i != OM_OFF) && !(pwm && (omode_i == OM_ALT));
endmodule

// File: rtl/tmr_wavegen.sv
module tmr_wavegen
  import tmr_wavegen_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [1:0]   wave_mode_i,
  input  logic [1:0]   out_mode_i,
  input  logic [W-1:0] cmp_val_i,
  output logic [W-1:0] count_o,
  output logic         wave_o,
  output logic         pin_en_o,
  output logic         match_o,
  output logic         ovf_o
);
  wave_mode_e   wmode;
  out_mode_e    omode;
  logic         pwm, up_d, ovf_d, ovf_q;
  logic [W-1:0] cnt_q, cnt_d, cmp_eff;

  assign wmode = wave_mode_e'(wave_mode_i);
  assign omode = out_mode_e'(out_mode_i);
  assign pwm   = (wmode == WM_PHASE) || (wmode == WM_FAST);

  tmr_count_core #(.W(W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .mode_i   (wmode),
    .ctc_top_i(cmp_val_i),
    .cnt_q_o  (cnt_q),
    .cnt_d_o  (cnt_d),
    .up_d_o   (up_d),
    .ovf_d_o  (ovf_d)
  );

  tmr_cmp_buf #(.W(W)) u_cmp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .pwm_i    (pwm),
    .cnt_d_i  (cnt_d),
    .cmp_val_i(cmp_val_i),
    .cmp_eff_o(cmp_eff)
  );

  tmr_out_ctl #(.W(W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .wmode_i  (wmode),
    .omode_i  (omode),
    .cnt_d_i  (cnt_d),
    .up_d_i   (up_d),
    .cmp_eff_i(cmp_eff),
    .wave_o   (wave_o),
    .match_o  (match_o),
    .pin_en_o (pin_en_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= tick_i && ovf_d;
  end

  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/tmr_wavegen_chk.sv
module tmr_wavegen_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic [1:0]   wave_mode_i,
  input logic [1:0]   out_mode_i,
  input logic [W-1:0] count_o,
  input logic         pin_en_o,
  input logic         match_o,
  input logic         ovf_o
);
  localparam logic [W-1:0] STEP = W'(1);

  // R2
  hold_on_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(count_o));

  // R2
  no_flag_on_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> (!match_o && !ovf_o));

  // R3
  ovf_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (count_o == '0));

  // R5
  triangle_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && wave_mode_i == 2'b01 && $stable(wave_mode_i)) |=>
      ((count_o == $past(count_o) + STEP) || (count_o == $past(count_o) - STEP)));

  // R6
  off_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_mode_i == 2'b00) |-> !pin_en_o);

  // R6
  reserved_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_mode_i == 2'b01 && wave_mode_i[0]) |-> !pin_en_o);
endmodule

bind tmr_wavegen tmr_wavegen_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .wave_mode_i(wave_mode_i),
  .out_mode_i (out_mode_i),
  .count_o    (count_o),
  .pin_en_o   (pin_en_o),
  .match_o    (match_o),
  .ovf_o      (ovf_o)
);

// File: tb/tmr_wavegen_bench.sv
`timescale 1ns/1ps
module tmr_wavegen_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [1:0] wave_mode_i = 2'b00;
  logic [1:0] out_mode_i = 2'b00;
  logic [7:0] cmp_val_i = 8'd0;
  logic [7:0] count_o;
  logic       wave_o, pin_en_o, match_o, ovf_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int m_cnt, m_act;
  bit m_up, m_wave, m_match, m_ovf;

  always #4 clk_i = ~clk_i;

  tmr_wavegen u_tmr_wavegen (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .wave_mode_i(wave_mode_i), .out_mode_i(out_mode_i), .cmp_val_i(cmp_val_i),
    .count_o(count_o), .wave_o(wave_o), .pin_en_o(pin_en_o),
    .match_o(match_o), .ovf_o(ovf_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (wm=%0d om=%0d cmp=%0d)",
               req, what, act, exp, wave_mode_i, out_mode_i, cmp_val_i);
    end
  endtask

  function automatic bit is_pwm(input int wm);
    return (wm == 1) || (wm == 3);
  endfunction

  // one model step for the coming clock edge
  task automatic model_step(input bit tk, input int wm, input int om, input int cv);
    int nxt, eff;
    bit go_up, hit, spec;
    if (!tk) begin
      m_match = 0; m_ovf = 0;
      if (!is_pwm(wm)) m_act = cv;
      return;
    end
    go_up = 1; m_ovf = 0;
    nxt = (m_cnt + 1) % 256;
    if (wm == 0 || wm == 3) m_ovf = (m_cnt == 255);
    else if (wm == 2) begin if (m_cnt == cv) nxt = 0; end
    else begin
      go_up = m_up ? (m_cnt != 255) : (m_cnt == 0);
      nxt = go_up ? m_cnt + 1 : m_cnt - 1;
      m_ovf = !go_up && (nxt == 0);
    end
    eff = is_pwm(wm) ? m_act : cv;
    hit = (nxt == eff);
    spec = (om >= 2) && (eff == 255);
    if (wm == 0 || wm == 2) begin
      if (hit) begin
        if (om == 1) m_wave = !m_wave;
        else if (om == 2) m_wave = 0;
        else if (om == 3) m_wave = 1;
      end
    end else if (wm == 3 && om >= 2) begin
      if (spec) begin if (nxt == 0) m_wave = (om == 2); end
      else if (hit) m_wave = (om == 3);
      else if (nxt == 0) m_wave = (om == 2);
    end else if (wm == 1 && om >= 2) begin
      if (spec) begin if (nxt == 255) m_wave = (om == 2); end
      else if (hit) m_wave = go_up ? (om == 3) : (om == 2);
    end
    m_match = hit;
    if (!is_pwm(wm) || nxt == 255) m_act = cv;
    m_cnt = nxt;
    m_up = go_up;
  endtask

  function automatic string cnt_req(input int wm, input bit gated);
    string s;
    s = (wm == 2) ? "R4" : (wm == 1) ? "R5" : "R3";
    if (gated) s = {s, "+R2"};
    return s;
  endfunction

  function automatic string wave_req(input int wm, input int om, input bit after_switch);
    string s;
    if (wm == 0 || wm == 2) s = "R7";
    else if (wm == 3) s = "R8";
    else s = "R9";
    if (om >= 2 && is_pwm(wm) && m_act == 255) s = {s, "+R10"};
    if (after_switch && is_pwm(wm)) s = {s, "+R11"};
    return s;
  endfunction

  task automatic run_cfg(input int wm, input int om, input int c1, input int c2, input bit gated);
    bit tk;
    rst_ni = 1'b0;
    wave_mode_i = 2'(wm); out_mode_i = 2'(om); cmp_val_i = 8'(c1); tick_i = 1'b0;
    repeat (2) @(negedge clk_i);
    m_cnt = 0; m_act = 0; m_up = 1; m_wave = 0; m_match = 0; m_ovf = 0;
    rst_ni = 1'b1;
    for (int k = 0; k < 1100; k++) begin
      @(negedge clk_i);
      check(cnt_req(wm, gated), "count", int'(count_o), m_cnt);
      check(wave_req(wm, om, k > 700), "wave", int'(wave_o), int'(m_wave));
      check("R12", "match", int'(match_o), int'(m_match));
      check(wm == 1 ? "R5" : "R3", "ovf", int'(ovf_o), int'(m_ovf));
      check("R6", "pin_en", int'(pin_en_o), int'((om != 0) && !(om == 1 && is_pwm(wm))));
      if (k == 700) cmp_val_i = 8'(c2);
      tk = gated ? (k % 3 != 2) : 1'b1;
      tick_i = tk;
      model_step(tk, wm, om, int'(cmp_val_i));
    end
  endtask

  initial begin
    int cmps[5];
    cmps[0] = 0; cmps[1] = 1; cmps[2] = 100; cmps[3] = 254; cmps[4] = 255;
    // R1: reset state with inputs that would otherwise act
    tick_i = 1'b1; wave_mode_i = 2'b11; out_mode_i = 2'b10; cmp_val_i = 8'd0;
    repeat (3) @(negedge clk_i);
    check("R1", "count", int'(count_o), 0);
    check("R1", "wave", int'(wave_o), 0);
    check("R1", "match", int'(match_o), 0);
    check("R1", "ovf", int'(ovf_o), 0);
    for (int wm = 0; wm < 4; wm++)
      for (int om = 0; om < 4; om++)
        for (int ci = 0; ci < 5; ci++)
          run_cfg(wm, om, cmps[ci], 255 - cmps[ci], ci[0]);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule